// File: doc/BRIEF.md
# Prebiased-Output Startup Sequencer

This block sequences the start of a synchronous step-down converter whose output may already hold a voltage when it is enabled. Until the analog soft-start ramp catches up with the feedback voltage, it holds both power switches off so that the charge on the output capacitor is not pulled away. Once the ramp crosses the feedback voltage, switching begins. When the prebias sits above the set point, a second comparator at a fixed force threshold starts switching without that crossing. In skip mode only prebias below the set point is supported, so the force path is disabled there.

For the first `WIN_CYCLES` switching periods the low-side sink current limit runs at a reduced threshold. In any switching period, if the low-side switch reaches its sink limit, the low side turns off for the rest of that period. The high side is then forced on with a reduced current limit, so that the reverse current recirculates through the high-side channel and not through its body diode. If the reduced high-side limit trips, the high side stays off until the period ends. The block drives gate-enable overrides and limit selections into the cycle controller. It also drives a flag that marks the end of the startup window.

Top module: `prebias_seq`

## Requirements
- R1: After reset, and whenever the sequencer is in hold-off, `hs_allow`, `ls_allow`, `hs_force`, `hs_lim_reduced` and `start_done` are 0 and `sink_lim_reduced` is 1.
- R2: With `en`=1 and `restart`=0, sampling `ss_above_fb`=1 in hold-off starts switching. From the next cycle, `hs_allow`=1 and `ls_allow`=1.
- R3: With `skip_mode`=0, sampling `ss_above_force`=1 in hold-off starts switching in the same way, even with `ss_above_fb`=0.
- R4: With `skip_mode`=1, `ss_above_force` has no effect. The sequencer stays in hold-off until `ss_above_fb` is seen.
- R5: `sink_lim_reduced` stays 1 until the `WIN_CYCLES`-th (default 32) `cycle_tick` sampled while switching. In the cycle after that tick it drops to 0 and `start_done` rises to 1. A `cycle_tick` sampled in the same cycle that switching starts is not counted. The window counter saturates and does not wrap.
- R6: While switching, `ls_sink_hit` sampled with no `cycle_tick` in the same cycle makes `ls_allow`=0, `hs_force`=1 and `hs_lim_reduced`=1 from the next cycle, with `hs_allow` still 1.
- R7: In that recirculation phase, `hs_red_hit` makes `hs_allow`=0, `hs_force`=0 and `hs_lim_reduced`=0 from the next cycle. This lasts until the period ends, and `ls_allow` stays 0.
- R8: A sampled `cycle_tick` ends the period. From the next cycle, `hs_allow`=`ls_allow`=1 and `hs_force`=0. A tick takes priority over a limit flag sampled in the same cycle.
- R9: `en`=0 or `restart`=1 returns the sequencer to hold-off on the next cycle and clears the window count. After the next start, a full window of `WIN_CYCLES` ticks is needed again.
- R10: In hold-off, `ls_sink_hit`, `hs_red_hit` and `cycle_tick` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; 0 forces hold-off |
| restart | input | 1 | Restart request; 1 forces hold-off |
| cycle_tick | input | 1 | One-cycle pulse marking the start of a switching period |
| skip_mode | input | 1 | 1 selects skip mode (force-threshold start disabled) |
| ss_above_fb | input | 1 | Soft-start ramp is above the feedback voltage |
| ss_above_force | input | 1 | Soft-start ramp is above the forced-start threshold |
| ls_sink_hit | input | 1 | Low-side reverse (sink) current limit reached |
| hs_red_hit | input | 1 | High-side reduced current limit reached |
| hs_allow | output | 1 | High-side gate enable override |
| ls_allow | output | 1 | Low-side gate enable override |
| hs_force | output | 1 | Force high side on for recirculation |
| sink_lim_reduced | output | 1 | 1 selects the reduced low-side sink limit |
| hs_lim_reduced | output | 1 | 1 selects the reduced high-side limit |
| start_done | output | 1 | Startup window finished |

## Verification
The bench first targets how the window is counted. It checks that a tick in the start cycle is excluded, that the 31st tick still leaves the reduced sink limit selected, and that the 32nd releases it. A counter that was off by one would release the limit a period early or late. It also checks that a restart clears the count, since a count left uncleared would give the second startup a short window. The bench drives a sink-limit hit and a period tick in the same cycle, where wrong priority would drop the low side for a whole period. It drives the forced-start flag in skip mode, where a missing qualifier would start switching into an above-set-point prebias. It also sends limit flags and ticks during hold-off and in the blanked phase, where leakage would turn a switch on too early.

// File: rtl/psq_pkg.sv
package psq_pkg;
   typedef enum logic [1:0] {
      PH_NORM   = 2'd0,
      PH_RECIRC = 2'd1,
      PH_BLANK  = 2'd2
   } psq_phase_t;
endpackage

// File: rtl/psq_arm.sv
module psq_arm #(
   parameter bit FORCE_IN_SKIP = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic ss_above_fb,
   input  logic ss_above_force,
   input  logic skip_mode,
   output logic running
);
   logic force_ok;

   generate
      if (FORCE_IN_SKIP) begin : g_force_any
         assign force_ok = ss_above_force;
         logic unused_skip;
         assign unused_skip = skip_mode;
      end else begin : g_force_pwm_only
         assign force_ok = ss_above_force && !skip_mode;

         // R4: forced threshold ignored in skip mode
         p_skip_no_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!running && !clear && skip_mode && !ss_above_fb) |=> !running);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
      end else if (clear) begin
         running <= 1'b0;
      end else if (!running && (ss_above_fb || force_ok)) begin
         running <= 1'b1;
      end
   end

   p_clear_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !running);
endmodule

// File: rtl/psq_window.sv
module psq_window #(
   parameter int WIN_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic running,
   input  logic cycle_tick,
   output logic reduced,
   output logic done
);
   localparam int CNT_W = $clog2(WIN_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_WIN = CNT_W'(WIN_CYCLES);

   generate
      if (WIN_CYCLES < 1) begin : g_bad_win
         $error("psq_window: WIN_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || !running) begin
         cnt <= '0;
      end else if (cycle_tick && (cnt != CNT_MAX)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done    = (cnt >= CNT_WIN);
   assign reduced = !done;

   // R5: saturation, no wrap
   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && running && !clear) |=> cnt == CNT_MAX);
   // R5: window ends only on a tick
   p_done_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(cycle_tick));
   // R9: clear empties the counter
   p_clear_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);
endmodule

// File: rtl/psq_recirc.sv
module psq_recirc
   import psq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       running,
   input  logic       cycle_tick,
   input  logic       ls_sink_hit,
   input  logic       hs_red_hit,
   output psq_phase_t phase
);
   psq_phase_t phase_nx;

   always_comb begin
      phase_nx = phase;
      if (clear || !running || cycle_tick) begin
         phase_nx = PH_NORM;
      end else begin
         case (phase)
            PH_NORM:   if (ls_sink_hit) phase_nx = PH_RECIRC;
            PH_RECIRC: if (hs_red_hit)  phase_nx = PH_BLANK;
            default:   phase_nx = phase;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_NORM;
      else        phase <= phase_nx;
   end

   // R7: blanking persists until the period ends
   p_blank_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BLANK && running && !clear && !cycle_tick) |=> phase == PH_BLANK);
   // R8: tick returns to normal phase
   p_tick_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_tick |=> phase == PH_NORM);
   // R10: no phase change while held off
   p_hold_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> (phase == PH_NORM));
endmodule

// File: rtl/prebias_seq.sv
module prebias_seq
   import psq_pkg::*;
#(
   parameter int WIN_CYCLES    = 32,
   parameter bit FORCE_IN_SKIP = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic restart,
   input  logic cycle_tick,
   input  logic skip_mode,
   input  logic ss_above_fb,
   input  logic ss_above_force,
   input  logic ls_sink_hit,
   input  logic hs_red_hit,
   output logic hs_allow,
   output logic ls_allow,
   output logic hs_force,
   output logic sink_lim_reduced,
   output logic hs_lim_reduced,
   output logic start_done
);
   logic       clear;
   logic       running;
   logic       win_reduced;
   logic       win_done;
   psq_phase_t phase;

   assign clear = !en || restart;

   psq_arm #(.FORCE_IN_SKIP(FORCE_IN_SKIP)) u_arm (
      .clk            (clk),
      .rst_n          (rst_n),
      .clear          (clear),
      .ss_above_fb    (ss_above_fb),
      .ss_above_force (ss_above_force),
      .skip_mode      (skip_mode),
      .running        (running)
   );

   psq_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .running    (running),
      .cycle_tick (cycle_tick),
      .reduced    (win_reduced),
      .done       (win_done)
   );

   psq_recirc u_rec (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .running     (running),
      .cycle_tick  (cycle_tick),
      .ls_sink_hit (ls_sink_hit),
      .hs_red_hit  (hs_red_hit),
      .phase       (phase)
   );

   assign hs_allow         = running && (phase != PH_BLANK);
   assign ls_allow         = running && (phase == PH_NORM);
   assign hs_force         = running && (phase == PH_RECIRC);
   assign hs_lim_reduced   = running && (phase == PH_RECIRC);
   assign sink_lim_reduced = win_reduced;
   assign start_done       = running && win_done;

   // R1: both switches off in hold-off
   p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!hs_allow && !ls_allow && !start_done && sink_lim_reduced));
   // R6: low side never on while high side is forced
   p_no_shoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hs_force |-> !ls_allow);
   // R6: sink hit moves into recirculation
   p_sink_recirc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_allow && ls_sink_hit && !cycle_tick && !clear) |=> (hs_force && !ls_allow));
   // R5: done and reduced sink limit are exclusive
   p_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_done |-> !sink_lim_reduced);
endmodule

// File: tb/prebias_seq_tb.sv
module prebias_seq_tb;
   localparam int WIN = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 0, restart = 0, cycle_tick = 0, skip_mode = 0;
   logic ss_above_fb = 0, ss_above_force = 0, ls_sink_hit = 0, hs_red_hit = 0;
   logic hs_allow, ls_allow, hs_force, sink_lim_reduced, hs_lim_reduced, start_done;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R1";
   bit finished = 0;

   always #10 clk = ~clk;

   prebias_seq #(.WIN_CYCLES(WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .cycle_tick(cycle_tick),
      .skip_mode(skip_mode), .ss_above_fb(ss_above_fb), .ss_above_force(ss_above_force),
      .ls_sink_hit(ls_sink_hit), .hs_red_hit(hs_red_hit), .hs_allow(hs_allow),
      .ls_allow(ls_allow), .hs_force(hs_force), .sink_lim_reduced(sink_lim_reduced),
      .hs_lim_reduced(hs_lim_reduced), .start_done(start_done)
   );

   // behavioural reference: 0 normal, 1 recirculating, 2 blanked
   bit m_run;
   int m_cnt;
   int m_ph;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run <= 0; m_cnt <= 0; m_ph <= 0;
      end else if (!en || restart) begin
         m_run <= 0; m_cnt <= 0; m_ph <= 0;
      end else if (!m_run) begin
         if (ss_above_fb || (ss_above_force && !skip_mode)) m_run <= 1;
         m_cnt <= 0; m_ph <= 0;
      end else if (cycle_tick) begin
         m_cnt <= (m_cnt >= 63) ? 63 : m_cnt + 1;
         m_ph <= 0;
      end else if (m_ph == 0 && ls_sink_hit) begin
         m_ph <= 1;
      end else if (m_ph == 1 && hs_red_hit) begin
         m_ph <= 2;
      end
   end

   function automatic logic [5:0] model_out();
      logic [5:0] o;
      o[5] = m_run && m_ph != 2;
      o[4] = m_run && m_ph == 0;
      o[3] = m_run && m_ph == 1;
      o[2] = (m_cnt < WIN);
      o[1] = m_run && m_ph == 1;
      o[0] = m_run && (m_cnt >= WIN);
      return o;
   endfunction

   task automatic chk(string req, logic act, logic exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         logic [5:0] act, exp;
         act = {hs_allow, ls_allow, hs_force, sink_lim_reduced, hs_lim_reduced, start_done};
         exp = model_out();
         n_chk++;
         if (act !== exp) begin
            n_fail++;
            $display("FAIL %s model compare actual=%b expected=%b at %0t", cur_req, act, exp, $time);
         end
      end
   end

   task automatic nxt(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #5;
      end
   endtask

   task automatic tick_once(int gap = 4);
      cycle_tick = 1; nxt(); cycle_tick = 0; nxt(gap);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      nxt(2);
      // R1 reset state
      chk("R1", hs_allow, 0, "hs_allow after reset");
      chk("R1", ls_allow, 0, "ls_allow after reset");
      chk("R1", sink_lim_reduced, 1, "sink reduced after reset");
      chk("R1", start_done, 0, "start_done after reset");
      rst_n = 1; nxt(2);
      cur_req = "R10"; en = 1;
      for (int i = 0; i < 12; i++) begin
         ls_sink_hit = i[0]; hs_red_hit = i[1]; cycle_tick = i[2]; nxt();
      end
      ls_sink_hit = 0; hs_red_hit = 0; cycle_tick = 0; nxt();
      chk("R10", hs_allow, 0, "hs_allow held off");
      chk("R10", hs_lim_reduced, 0, "hs limit in hold");
      // R4 skip mode ignores force threshold
      cur_req = "R4"; skip_mode = 1; ss_above_force = 1; nxt(10);
      chk("R4", hs_allow, 0, "force in skip");
      chk("R4", ls_allow, 0, "force in skip ls");
      // R2 crossing start, with a tick in the start cycle (not counted, R5)
      cur_req = "R2"; ss_above_fb = 1; cycle_tick = 1; nxt();
      cycle_tick = 0;
      chk("R2", hs_allow, 1, "hs after crossing");
      chk("R2", ls_allow, 1, "ls after crossing");
      ss_above_fb = 0; ss_above_force = 0; nxt(3);
      cur_req = "R5";
      for (int i = 0; i < WIN - 1; i++) tick_once(3);
      chk("R5", sink_lim_reduced, 1, "reduced after 31 ticks");
      chk("R5", start_done, 0, "done after 31 ticks");
      cycle_tick = 1; nxt(); cycle_tick = 0;
      chk("R5", sink_lim_reduced, 0, "reduced after 32 ticks");
      chk("R5", start_done, 1, "done after 32 ticks");
      for (int i = 0; i < 40; i++) tick_once(1);
      chk("R5", start_done, 1, "done held at saturation");
      // R6 / R7 / R8 recirculation
      cur_req = "R6"; ls_sink_hit = 1; nxt(); ls_sink_hit = 0;
      chk("R6", ls_allow, 0, "ls off after sink hit");
      chk("R6", hs_force, 1, "hs forced");
      chk("R6", hs_lim_reduced, 1, "hs limit reduced");
      chk("R6", hs_allow, 1, "hs allowed");
      nxt(2);
      cur_req = "R7"; hs_red_hit = 1; nxt(); hs_red_hit = 0;
      chk("R7", hs_allow, 0, "hs off after reduced limit");
      chk("R7", hs_force, 0, "force dropped");
      ls_sink_hit = 1; nxt(3); ls_sink_hit = 0;
      chk("R7", ls_allow, 0, "ls stays off in blank");
      chk("R7", hs_allow, 0, "hs stays off in blank");
      cur_req = "R8"; cycle_tick = 1; nxt(); cycle_tick = 0;
      chk("R8", hs_allow, 1, "hs after tick");
      chk("R8", ls_allow, 1, "ls after tick");
      cycle_tick = 1; ls_sink_hit = 1; nxt(); cycle_tick = 0; ls_sink_hit = 0;
      chk("R8", ls_allow, 1, "tick beats sink hit");
      chk("R8", hs_force, 0, "no force after tick+hit");
      // R9 restart clears, then R3 force start
      cur_req = "R9"; restart = 1; nxt(); restart = 0;
      chk("R9", hs_allow, 0, "hold after restart");
      chk("R9", sink_lim_reduced, 1, "window reset");
      nxt(3);
      cur_req = "R3"; skip_mode = 0; ss_above_force = 1; nxt(); ss_above_force = 0;
      chk("R3", hs_allow, 1, "force start hs");
      chk("R3", ls_allow, 1, "force start ls");
      cur_req = "R9";
      for (int i = 0; i < WIN - 1; i++) tick_once(2);
      chk("R9", start_done, 0, "full window after restart");
      tick_once(0);
      chk("R9", start_done, 1, "window done after restart");
      en = 0; nxt();
      chk("R9", ls_allow, 0, "disable holds off");
      chk("R1", sink_lim_reduced, 1, "hold state sink reduced");
      // mixed stimulus
      cur_req = "R2";
      for (int i = 0; i < 6000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         en = (lfsr[9:4] != 0);
         restart = (lfsr[15:11] == 0);
         cycle_tick = (i % 7 == 0);
         skip_mode = lfsr[3] & lfsr[8];
         ss_above_fb = lfsr[2] & lfsr[5] & lfsr[7];
         ss_above_force = lfsr[6] & lfsr[1];
         ls_sink_hit = lfsr[0] & lfsr[10];
         hs_red_hit = lfsr[11] & lfsr[12];
         nxt();
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule